// File: doc/BRIEF.md
# Shared-Pin External Memory Sequencer

This block turns single 16-bit requests from an internal port into access sequences on one external memory bus. The bus has a single set of address pins. Linear-addressed ROM and static RAM use those pins, and so does a dynamic RAM, which receives its address as a row and then a column on the low pins. At the moment a request is accepted, the sequencer samples an external decode input. That input decides whether the access runs as a linear cycle or as a row/column cycle.

Static RAM can be 8 bits wide on the second chip select. In that case, one request becomes two byte phases that differ only in a byte-select pin. The two bytes are joined into one 16-bit word. After reset, the sequencer reads two strap levels once to decide whether the dynamic memory is a DRAM or an SDRAM. For an SDRAM, it then runs a configuration phase. During every SDRAM column phase it asks for auto-precharge.

Strobes are active high. Every phase lasts `PH_CYC` clocks.

Top module: `xmem_seq`

## Requirements
- R1: While `rst` is high, `req_busy` is 1 and `rd_valid` and all bus strobes (`bus_lin_cs`, `bus_cs2`, `bus_ras`, `bus_cas`, `bus_cfg`, `bus_bsel`, `bus_we`) are 0.
- R2: On the first clock edge after reset release, `mem_is_sdram` latches `strap_ras & ~strap_cas`. Strap changes after that edge have no effect until the next reset.
- R3: With an SDRAM, the second edge after reset release starts a configuration phase. It lasts `PH_CYC` cycles with only `bus_cfg` high, address bit 0 = `CFG_LO`, address bit `MW-1` = `CFG_HI` and all other address bits 0. `req_busy` falls when the phase ends. With a DRAM there is no configuration phase, and `req_busy` falls after the second edge.
- R4: A request is taken at an edge where `req_valid` is 1 and `req_busy` is 0. `req_busy` is 1 from the next cycle until the sequence ends.
- R5: `mem_dram_sel` is sampled only at the accepting edge (1 = row/column sequence, 0 = linear). Later changes do not alter the running sequence.
- R6: A 16-bit linear access is one phase: `bus_lin_cs` high, `bus_cs2` = `req_cs2`, `bus_addr` = `req_addr`, `bus_bsel` 0.
- R7: A row/column access is a row phase (`bus_ras` only, `bus_addr[MW-1:0]` = `req_addr[2*MW-1:MW]`, other pins 0) followed by a column phase (`bus_ras` and `bus_cas`, `bus_addr[MW-1:0]` = `req_addr[MW-1:0]`, other pins 0).
- R8: In SDRAM mode, column-phase address bit 10 is forced to 1. In DRAM mode it carries the column bit.
- R9: Only a linear access with `cfg_sram8` = 1 and `req_cs2` = 1 runs as two byte phases on the same address, first with `bus_bsel` 0 and then with `bus_bsel` 1. Any other linear access is 16-bit.
- R10: In byte mode, a read takes `bus_rdata[7:0]` of the first phase as the low byte and that of the second phase as the high byte. A write drives `req_wdata[7:0]` and then `req_wdata[15:8]` on `bus_wdata[7:0]`, with the upper bits 0.
- R11: A read ends with a one-cycle `rd_valid`, in the same cycle that `req_busy` falls. `rd_data` holds the word sampled at the last edge of each phase. A write gives no `rd_valid`. `bus_we` is high, and `bus_wdata` carries write data, only during write phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_ras | input | 1 | Row-strobe strap level |
| strap_cas | input | 1 | Column-strobe strap level |
| cfg_sram8 | input | 1 | Control bit: 8-bit SRAM on second chip select |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | Request is a write |
| req_cs2 | input | 1 | Request targets the second SRAM chip select |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_busy | output | 1 | Sequencer busy, request not taken |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Read data |
| mem_dram_sel | input | 1 | External decode: 1 = dynamic RAM cycle |
| mem_is_sdram | output | 1 | Latched memory type, 1 = SDRAM |
| bus_addr | output | AW | Shared address pins |
| bus_lin_cs | output | 1 | Linear access strobe |
| bus_cs2 | output | 1 | Second SRAM chip select |
| bus_ras | output | 1 | Row strobe |
| bus_cas | output | 1 | Column strobe |
| bus_cfg | output | 1 | SDRAM configuration strobe |
| bus_bsel | output | 1 | Byte-select address bit |
| bus_we | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data to memory |
| bus_rdata | input | DW | Read data from memory |

## Verification
The bench builds the block with `PH_CYC` = 2 and both configuration bits set to 1. Two-cycle phases make the phase counter roll over inside each phase, and they keep each phase boundary apart from the final `rd_valid` cycle. Both configuration pins are visibly driven.

The bench resets the block under all four strap combinations. Under each one it sweeps every combination of memory select, direction, byte-mode bit and chip select over three addresses. Each sweep includes an address whose column bit 10 is clear, so the auto-precharge forcing can be told apart from plain address pass-through.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_CFG   = 3'd2,
    ST_LIN   = 3'd3,
    ST_BYTE0 = 3'd4,
    ST_BYTE1 = 3'd5,
    ST_ROW   = 3'd6,
    ST_COL   = 3'd7
  } seq_st_e;

  localparam int AP_BIT = 10;

  function automatic logic is_linear(seq_st_e s);
    return (s == ST_LIN) || (s == ST_BYTE0) || (s == ST_BYTE1);
  endfunction

  function automatic logic is_data(seq_st_e s);
    return is_linear(s) || (s == ST_ROW) || (s == ST_COL);
  endfunction

endpackage

// File: rtl/xmem_strap.sv
module xmem_strap (
  input  logic clk,
  input  logic rst,
  input  logic strap_ras,
  input  logic strap_cas,
  output logic done,
  output logic is_sdram
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      is_sdram <= 1'b0;
    end else if (!done) begin
      done     <= 1'b1;
      is_sdram <= strap_ras & ~strap_cas;
    end
  end

  assert_type_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(is_sdram));

endmodule

// File: rtl/xmem_addr.sv
module xmem_addr import xmem_pkg::*; #(
  parameter int AW     = 27,
  parameter int MW     = 12,
  parameter bit CFG_LO = 1'b1,
  parameter bit CFG_HI = 1'b0
) (
  input  seq_st_e       st,
  input  logic [AW-1:0] addr,
  input  logic          sdram,
  output logic [AW-1:0] pins
);

  always_comb begin
    pins = '0;
    case (st)
      ST_LIN, ST_BYTE0, ST_BYTE1: pins = addr;
      ST_ROW: pins[MW-1:0] = addr[2*MW-1:MW];
      ST_COL: begin
        pins[MW-1:0] = addr[MW-1:0];
        if (sdram) pins[AP_BIT] = 1'b1;
      end
      ST_CFG: begin
        pins[0]    = CFG_LO;
        pins[MW-1] = CFG_HI;
      end
      default: pins = '0;
    endcase
  end

endmodule

// File: rtl/xmem_pack.sv
module xmem_pack #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_full,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] word
);

  localparam int BW = DW / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (cap_full) begin
      word <= rdata;
    end else begin
      if (cap_lo) word[BW-1:0]  <= rdata[BW-1:0];
      if (cap_hi) word[DW-1:BW] <= rdata[BW-1:0];
    end
  end

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq import xmem_pkg::*; #(
  parameter int AW     = 27,
  parameter int MW     = 12,
  parameter int DW     = 16,
  parameter int PH_CYC = 2,
  parameter bit CFG_LO = 1'b1,
  parameter bit CFG_HI = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_ras,
  input  logic          strap_cas,
  input  logic          cfg_sram8,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          req_cs2,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          mem_dram_sel,
  output logic          mem_is_sdram,
  output logic [AW-1:0] bus_addr,
  output logic          bus_lin_cs,
  output logic          bus_cs2,
  output logic          bus_ras,
  output logic          bus_cas,
  output logic          bus_cfg,
  output logic          bus_bsel,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  localparam int BW = DW / 2;
  localparam int CW = (PH_CYC > 1) ? $clog2(PH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PH_CYC - 1);

  logic strap_done;
  seq_st_e st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic accept, done, cap_full, cap_lo, cap_hi;
  logic [AW-1:0] addr_q, addr_n, pins_n;
  logic [DW-1:0] wd_q, wd_n, bus_wd_n;
  logic we_q, we_n, cs2_q, cs2_n;

  xmem_strap u_strap (
    .clk(clk), .rst(rst), .strap_ras(strap_ras), .strap_cas(strap_cas),
    .done(strap_done), .is_sdram(mem_is_sdram)
  );

  // Sequence control: one phase per state, each held PH_CYC clocks.
  always_comb begin
    st_n = st; cnt_n = cnt; accept = 1'b0; done = 1'b0;
    cap_full = 1'b0; cap_lo = 1'b0; cap_hi = 1'b0;
    case (st)
      ST_INIT: begin
        cnt_n = '0;
        if (strap_done) st_n = mem_is_sdram ? ST_CFG : ST_IDLE;
      end
      ST_IDLE: begin
        cnt_n = '0;
        if (req_valid) begin
          accept = 1'b1;
          if (mem_dram_sel)           st_n = ST_ROW;
          else if (cfg_sram8 && req_cs2) st_n = ST_BYTE0;
          else                        st_n = ST_LIN;
        end
      end
      default: begin
        if (cnt == LAST) begin
          cnt_n = '0;
          case (st)
            ST_CFG:   st_n = ST_IDLE;
            ST_LIN:   begin st_n = ST_IDLE;  done = 1'b1; cap_full = !we_q; end
            ST_BYTE0: begin st_n = ST_BYTE1; cap_lo = !we_q; end
            ST_BYTE1: begin st_n = ST_IDLE;  done = 1'b1; cap_hi = !we_q; end
            ST_ROW:   st_n = ST_COL;
            ST_COL:   begin st_n = ST_IDLE;  done = 1'b1; cap_full = !we_q; end
            default:  st_n = ST_IDLE;
          endcase
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
    endcase
  end

  assign addr_n = accept ? req_addr  : addr_q;
  assign wd_n   = accept ? req_wdata : wd_q;
  assign we_n   = accept ? req_we    : we_q;
  assign cs2_n  = accept ? req_cs2   : cs2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_INIT; cnt <= '0;
      addr_q <= '0; wd_q <= '0; we_q <= 1'b0; cs2_q <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n;
      addr_q <= addr_n; wd_q <= wd_n; we_q <= we_n; cs2_q <= cs2_n;
    end
  end

  xmem_addr #(.AW(AW), .MW(MW), .CFG_LO(CFG_LO), .CFG_HI(CFG_HI)) u_addr (
    .st(st_n), .addr(addr_n), .sdram(mem_is_sdram), .pins(pins_n)
  );

  always_comb begin
    bus_wd_n = '0;
    if (we_n) begin
      case (st_n)
        ST_LIN, ST_ROW, ST_COL: bus_wd_n = wd_n;
        ST_BYTE0: bus_wd_n[BW-1:0] = wd_n[BW-1:0];
        ST_BYTE1: bus_wd_n[BW-1:0] = wd_n[DW-1:BW];
        default:  bus_wd_n = '0;
      endcase
    end
  end

  // Registered pin stage, loaded from the next-phase decode.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0; bus_lin_cs <= 1'b0; bus_cs2 <= 1'b0; bus_ras <= 1'b0;
      bus_cas <= 1'b0; bus_cfg <= 1'b0; bus_bsel <= 1'b0; bus_we <= 1'b0;
      bus_wdata <= '0; req_busy <= 1'b1; rd_valid <= 1'b0;
    end else begin
      bus_addr   <= pins_n;
      bus_lin_cs <= is_linear(st_n);
      bus_cs2    <= is_linear(st_n) && cs2_n;
      bus_ras    <= (st_n == ST_ROW) || (st_n == ST_COL);
      bus_cas    <= (st_n == ST_COL);
      bus_cfg    <= (st_n == ST_CFG);
      bus_bsel   <= (st_n == ST_BYTE1);
      bus_we     <= is_data(st_n) && we_n;
      bus_wdata  <= bus_wd_n;
      req_busy   <= (st_n != ST_IDLE);
      rd_valid   <= done && !we_q;
    end
  end

  xmem_pack #(.DW(DW)) u_pack (
    .clk(clk), .rst(rst), .cap_full(cap_full), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .rdata(bus_rdata), .word(rd_data)
  );

  assert_lin_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    bus_lin_cs |-> (!bus_ras && !bus_cas));
  assert_col_after_row_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cas) |-> $past(bus_ras));
  assert_autoprecharge_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_cas && mem_is_sdram) |-> bus_addr[AP_BIT]);
  assert_bsel_cs2_R9: assert property (@(posedge clk) disable iff (rst)
    bus_bsel |-> (bus_lin_cs && bus_cs2));
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  assert_valid_ready_R11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !req_busy);
  assert_cfg_idle_R3: assert property (@(posedge clk) disable iff (rst)
    bus_cfg |-> (req_busy && !bus_ras && !bus_lin_cs));

endmodule

// File: tb/test_xmem_seq.sv
module test_xmem_seq;
  localparam int AW = 27, MW = 12, DW = 16, PH = 2;
  localparam bit CLO = 1'b1, CHI = 1'b1;

  logic clk = 1'b0, rst = 1'b1;
  logic strap_ras = 1'b0, strap_cas = 1'b0, cfg_sram8 = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_cs2 = 1'b0, mem_dram_sel = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_busy, rd_valid, mem_is_sdram;
  logic [DW-1:0] rd_data, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic bus_lin_cs, bus_cs2, bus_ras, bus_cas, bus_cfg, bus_bsel, bus_we;
  int errors = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] mdl(logic [AW-1:0] a, logic b);
    logic [DW-1:0] v = 16'(a[15:0] * 16'd7 + 16'h1234);
    return b ? (v ^ 16'h00A5) : v;
  endfunction

  assign bus_rdata = mdl(bus_addr, bus_bsel);

  xmem_seq #(.AW(AW), .MW(MW), .DW(DW), .PH_CYC(PH), .CFG_LO(CLO), .CFG_HI(CHI)) i_xmem_seq (
    .clk(clk), .rst(rst), .strap_ras(strap_ras), .strap_cas(strap_cas),
    .cfg_sram8(cfg_sram8), .req_valid(req_valid), .req_we(req_we),
    .req_cs2(req_cs2), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_busy(req_busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_dram_sel(mem_dram_sel), .mem_is_sdram(mem_is_sdram),
    .bus_addr(bus_addr), .bus_lin_cs(bus_lin_cs), .bus_cs2(bus_cs2),
    .bus_ras(bus_ras), .bus_cas(bus_cas), .bus_cfg(bus_cfg),
    .bus_bsel(bus_bsel), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [6:0] ctl();
    return {bus_lin_cs, bus_cs2, bus_ras, bus_cas, bus_cfg, bus_bsel, bus_we};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset(input logic r, input logic c);
    logic sd;
    rst = 1'b1; strap_ras = r; strap_cas = c; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_busy && !rd_valid && ctl() == 7'b0, "R1 reset state", {24'b0, req_busy, ctl()}, 32'h80);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    sd = r & ~c;
    chk(mem_is_sdram == sd, "R2 strap latch", 32'(mem_is_sdram), 32'(sd));
    chk(req_busy, "R4 busy during init", 32'(req_busy), 1);
    strap_ras = ~r; strap_cas = ~c;
    @(posedge clk); @(negedge clk);
    if (sd) begin
      for (int k = 0; k < PH; k++) begin
        if (k > 0) @(negedge clk);
        chk(ctl() == 7'b0000100 && req_busy, "R3 config strobe", {25'b0, ctl()}, 32'h4);
        chk(bus_addr == (27'(CLO) | (27'(CHI) << (MW-1))), "R3 config pins", 32'(bus_addr), 32'(27'(CLO) | (27'(CHI) << (MW-1))));
      end
      @(negedge clk);
    end
    chk(!req_busy, "R3 ready after init", 32'(req_busy), 0);
    chk(mem_is_sdram == sd, "R2 strap change ignored", 32'(mem_is_sdram), 32'(sd));
  endtask

  task automatic txn(input logic dsel, input logic we, input logic s8, input logic cs2, input logic [AW-1:0] a);
    logic byte_m = !dsel && s8 && cs2;
    int nph = (dsel || byte_m) ? 2 : 1;
    logic [DW-1:0] wd = a[15:0] ^ 16'hBEEF;
    logic [AW-1:0] colp = 27'(a[MW-1:0]) | (mem_is_sdram ? 27'h400 : 27'h0);
    logic [DW-1:0] exp_rd;
    logic [AW-1:0] ep; logic [6:0] ec; logic [DW-1:0] ew; string tg;
    if (dsel)        exp_rd = mdl(colp, 1'b0);
    else if (byte_m) exp_rd = {mdl(a, 1'b1)[7:0], mdl(a, 1'b0)[7:0]};
    else             exp_rd = mdl(a, 1'b0);
    req_valid = 1'b1; req_we = we; req_cs2 = cs2; req_addr = a; req_wdata = wd;
    cfg_sram8 = s8; mem_dram_sel = dsel;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; mem_dram_sel = ~dsel; cfg_sram8 = ~s8;
    for (int p = 0; p < nph; p++) begin
      for (int k = 0; k < PH; k++) begin
        if (p > 0 || k > 0) @(negedge clk);
        if (dsel) begin
          ep = (p == 0) ? 27'(a[2*MW-1:MW]) : colp;
          ec = {2'b00, 1'b1, p[0], 2'b00, we};
          ew = we ? wd : 16'h0;
          tg = (p == 0) ? "R7 row phase (R5 sel held)" : "R7 column phase";
          if (p == 1) chk(bus_addr[10] == (mem_is_sdram | a[10]), "R8 precharge bit", 32'(bus_addr[10]), 32'(mem_is_sdram | a[10]));
        end else if (byte_m) begin
          ep = a; ec = {1'b1, 1'b1, 3'b000, p[0], we};
          ew = we ? {8'h00, (p == 0) ? wd[7:0] : wd[15:8]} : 16'h0;
          tg = "R9 byte phase";
          if (we) chk(bus_wdata == ew, "R10 byte write data", 32'(bus_wdata), 32'(ew));
        end else begin
          ep = a; ec = {1'b1, cs2, 4'b0000, we};
          ew = we ? wd : 16'h0;
          tg = "R6 linear phase (R5 sel held)";
        end
        chk(bus_addr == ep, tg, 32'(bus_addr), 32'(ep));
        chk(ctl() == ec, tg, 32'(ctl()), 32'(ec));
        chk(bus_wdata == ew, "R11 write data", 32'(bus_wdata), 32'(ew));
        chk(req_busy && !rd_valid, "R4 busy in sequence", {req_busy, rd_valid}, 2);
      end
    end
    @(negedge clk);
    chk(!req_busy, "R4 busy falls", 32'(req_busy), 0);
    chk(rd_valid == !we, "R11 read valid", 32'(rd_valid), 32'(!we));
    if (!we) chk(rd_data == exp_rd, byte_m ? "R10 byte assembly" : "R11 read data", 32'(rd_data), 32'(exp_rd));
  endtask

  initial begin
    logic [AW-1:0] addrs [3];
    addrs[0] = 27'h0000000; addrs[1] = 27'h7FFFFFF; addrs[2] = 27'h5A5C3F1;
    for (int s = 0; s < 4; s++) begin
      do_reset(s[1], s[0]);
      for (int v = 0; v < 16; v++)
        for (int i = 0; i < 3; i++)
          txn(v[3], v[2], v[1], v[0], addrs[i]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule